// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

An 8-bit up-counting timer that compares its count against a software-programmed period value. The count advances on a base tick running at one quarter of the system clock, further divided by a selectable input prescaler. When the count equals the period at an advance, the block raises a single-cycle match pulse and returns the count to zero on the following cycle. Other logic, for example a serial shift clock generator, can use that pulse directly.

A postscaler counts match pulses. After a programmed number of them it sets a sticky interrupt flag, and software clears that flag with a write. Software reaches the counter, the period value, the control settings and the flag through a small register interface of four addresses. A write to the counter or to the control register restarts the hidden prescale and postscale counts. A control write leaves the count itself untouched.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the control register reads 00h, the flag reads 0 and no match pulse is driven.
- R2: Address 0 is the counter, address 1 the period, address 2 the control register (bits 6:0 stored, bit 7 reads 0), address 3 the flag in bit 0. Written values read back on `rd_data_o` in the same cycle the address is presented.
- R3: Control bit 2 is the run bit. While it is 1 with prescale code 0, the counter advances once every 4 system clocks. While it is 0, the counter holds its value.
- R4: Control bits 1:0 select the prescale ratio: 00 gives 1, 01 gives 4, 10 or 11 gives 16 base ticks per advance.
- R5: An advance that finds the counter equal to the period raises `match_o` for one cycle, and the counter reads 00h on the next cycle.
- R6: Control bits 6:3 hold a value N. The flag sets on the (N+1)-th match pulse counted since the postscale count was last cleared.
- R7: The flag stays set until a write to address 3 with data bit 0 equal to 0. A write with bit 0 equal to 1 has no effect. A set in the same cycle as a clear wins.
- R8: A write to the counter or to the control register clears the prescale and postscale counts. A control write does not change the counter value.
- R9: If the counter is above the period, it counts up through FFh, wraps to 00h and matches only when it reaches the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe for the current cycle |
| addr_i | input | 2 | Register address for both read and write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| match_o | output | 1 | Single-cycle period-match pulse |
| irq_o | output | 1 | Sticky postscaler interrupt flag |

## Verification
Most hidden state in this block only reaches the ports after a delay.

- **Prescale count.** A wrong value shifts the next advance of the readable counter by up to 15 base ticks, so it shows within 64 system clocks.
- **Postscale count.** A stale value moves the flag edge by one or more whole periods, so the bench counts match pulses up to the flag edge.
- **Compare and reload.** A fault here shows on the very next cycle as a nonzero counter after a match, or as a match at the wrong count.

The bench therefore compares a cycle-level reference of the ports every cycle and adds directed checks timed over whole multiples of the base tick.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int POST_W = 4;
  localparam int PSEL_W = 2;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  // control layout: post divide [6:3], run [2], prescale select [1:0]
  typedef struct packed {
    logic [POST_W-1:0] post_div;
    logic              run;
    logic [PSEL_W-1:0] pre_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pt_prescale.sv
module pt_prescale #(
  parameter int TICK_DIV = 4,
  parameter int PRE_W    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       adv_o
);

  localparam int MID_W = PRE_W / 2;

  logic base_tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PH_W = $clog2(TICK_DIV);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);
      logic [PH_W-1:0] ph_q, ph_d;

      always_comb begin
        ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
      end

      assign base_tick = (ph_q == PH_LAST);
    end else begin : g_nodiv
      assign base_tick = 1'b1;
    end
  endgenerate

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;
  logic             step;
  logic             hit;

  assign step = run_i & base_tick;

  always_comb begin
    unique case (sel_i)
      2'd0:    hit = 1'b1;
      2'd1:    hit = &pre_q[MID_W-1:0];
      default: hit = &pre_q;
    endcase
  end

  always_comb begin
    pre_en = clr_i | step;
    if (clr_i) pre_d = '0;
    else       pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  assign adv_o = step & hit;

endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             equal;

  assign equal   = (cnt_q == period_i);
  assign match_o = adv_i & equal;

  always_comb begin
    cnt_en = wr_i | adv_i;
    if (wr_i)         cnt_d = wdata_i;
    else if (match_o) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pt_postscale.sv
module pt_postscale #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic             flag_clr_i,
  output logic             flag_o
);

  logic [SEL_W-1:0] post_q, post_d;
  logic             post_en;
  logic             wrap;
  logic             flag_q, flag_d;
  logic             flag_en;

  assign wrap = match_i & (post_q == ratio_i);

  always_comb begin
    post_en = clr_i | match_i;
    if (clr_i || wrap) post_d = '0;
    else               post_d = post_q + 1'b1;
  end

  always_comb begin
    flag_en = wrap | flag_clr_i;
    flag_d  = wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      post_q <= '0;
    else if (post_en) post_q <= post_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/period_timer.sv
module period_timer
  import pt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 4,
  parameter int PRE_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             match_o,
  output logic             irq_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // write decode
  reg_sel_e sel;
  logic     wr_cnt, wr_per, wr_ctl, flag_clr, hidden_clr;

  assign sel        = reg_sel_e'(addr_i);
  assign wr_cnt     = wr_en_i & (sel == REG_COUNT);
  assign wr_per     = wr_en_i & (sel == REG_PERIOD);
  assign wr_ctl     = wr_en_i & (sel == REG_CTRL);
  assign flag_clr   = wr_en_i & (sel == REG_FLAG) & ~wr_data_i[0];
  assign hidden_clr = wr_cnt | wr_ctl;

  // period and control registers
  logic [CNT_W-1:0] per_q;
  ctrl_t            ctrl_q, ctrl_d;

  assign ctrl_d = ctrl_t'(wr_data_i[CTRL_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)  per_q <= '1;
    else if (wr_per) per_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)  ctrl_q <= '0;
    else if (wr_ctl) ctrl_q <= ctrl_d;
  end

  // datapath
  logic             cnt_adv;
  logic [CNT_W-1:0] cnt_q;

  pt_prescale #(
    .TICK_DIV (TICK_DIV),
    .PRE_W    (PRE_W)
  ) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .run_i  (ctrl_q.run),
    .clr_i  (hidden_clr),
    .sel_i  (ctrl_q.pre_sel),
    .adv_o  (cnt_adv)
  );

  pt_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .adv_i    (cnt_adv),
    .wr_i     (wr_cnt),
    .wdata_i  (wr_data_i),
    .period_i (per_q),
    .cnt_o    (cnt_q),
    .match_o  (match_o)
  );

  pt_postscale #(
    .SEL_W (POST_W)
  ) u_postscale (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .match_i    (match_o),
    .clr_i      (hidden_clr),
    .ratio_i    (ctrl_q.post_div),
    .flag_clr_i (flag_clr),
    .flag_o     (irq_o)
  );

  // read mux
  always_comb begin
    unique case (sel)
      REG_COUNT:  rd_data_o = cnt_q;
      REG_PERIOD: rd_data_o = per_q;
      REG_CTRL:   rd_data_o = CNT_W'(ctrl_q);
      default:    rd_data_o = CNT_W'(irq_o);
    endcase
  end

endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int CTRL_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic              wdata0_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  per_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              adv_i,
  input logic              match_i,
  input logic              irq_i
);

  logic wr_cnt, wr_ctl, clr_flag;
  assign wr_cnt   = wr_en_i & (addr_i == 2'd0);
  assign wr_ctl   = wr_en_i & (addr_i == 2'd2);
  assign clr_flag = wr_en_i & (addr_i == 2'd3) & ~wdata0_i;

  assert_match_at_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> (cnt_i == per_i));

  assert_reload_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !wr_cnt) |=> (cnt_i == '0));

  assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[2] && !wr_cnt) |=> $stable(cnt_i));

  assert_ctrl_write_keeps_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && !adv_i) |=> $stable(cnt_i));

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_flag) |=> irq_i);

  assert_flag_from_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(match_i));

endmodule

bind period_timer period_timer_chk #(
  .CNT_W  (CNT_W),
  .CTRL_W (pt_pkg::CTRL_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_int_n),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata0_i (wr_data_i[0]),
  .cnt_i    (cnt_q),
  .per_i    (per_q),
  .ctrl_i   (ctrl_q),
  .adv_i    (cnt_adv),
  .match_i  (match_o),
  .irq_i    (irq_o)
);

// File: tb/period_timer_tb_top.sv
`timescale 1ns/1ps
module period_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rd_data;
  logic       match;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  period_timer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rd_data),
    .match_o   (match),
    .irq_o     (irq)
  );

  // cycle-level reference built from the requirements
  logic [1:0] m_rs, m_ph;
  logic [3:0] m_pre, m_post;
  logic [7:0] m_tmr, m_pr;
  logic [6:0] m_ctl;
  logic       m_flg, m_adv, m_match;

  always_comb begin
    m_adv = m_ctl[2] && (m_ph == 2'd3) &&
            ((m_ctl[1:0] == 2'd0) ||
             (m_ctl[1:0] == 2'd1 && m_pre[1:0] == 2'd3) ||
             (m_ctl[1:0] >= 2'd2 && m_pre == 4'd15));
    m_match = m_adv && (m_tmr == m_pr);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_ph <= 2'd0; m_pre <= 4'd0; m_post <= 4'd0;
      m_tmr <= 8'h00; m_pr <= 8'hFF; m_ctl <= 7'd0; m_flg <= 1'b0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin
        m_ph <= m_ph + 2'd1;
        if (wr_en && (addr == 2'd0 || addr == 2'd2)) m_pre <= 4'd0;
        else if (m_ctl[2] && m_ph == 2'd3)           m_pre <= m_pre + 4'd1;
        if (wr_en && addr == 2'd0) m_tmr <= wdata;
        else if (m_match)          m_tmr <= 8'h00;
        else if (m_adv)            m_tmr <= m_tmr + 8'd1;
        if (wr_en && addr == 2'd1) m_pr  <= wdata;
        if (wr_en && addr == 2'd2) m_ctl <= wdata[6:0];
        if (wr_en && (addr == 2'd0 || addr == 2'd2)) m_post <= 4'd0;
        else if (m_match) m_post <= (m_post == m_ctl[6:3]) ? 4'd0 : m_post + 4'd1;
        if (m_match && m_post == m_ctl[6:3])         m_flg <= 1'b1;
        else if (wr_en && addr == 2'd3 && !wdata[0]) m_flg <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [7:0] exp_rd;
    if (rst_n && m_rs[1]) begin
      case (addr)
        2'd0: exp_rd = m_tmr;
        2'd1: exp_rd = m_pr;
        2'd2: exp_rd = {1'b0, m_ctl};
        default: exp_rd = {7'd0, m_flg};
      endcase
      check(rd_data == exp_rd, "R2 rd_data vs reference", rd_data, exp_rd);
      check(match == m_match, "R5 match vs reference", match, m_match);
      check(irq == m_flg, "R7 flag vs reference", irq, m_flg);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmp_model();
    wr_en = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, addr, 8'd0);
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
    cyc(1'b0, a, 8'd0);
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  typedef struct packed {
    logic       wr;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] hold;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    {1'b1, 2'd1, 8'h05, 8'd0},   {1'b1, 2'd2, 8'h04, 8'd200},
    {1'b1, 2'd3, 8'h00, 8'd0},   {1'b1, 2'd2, 8'h14, 8'd250},
    {1'b1, 2'd2, 8'h1D, 8'd250}, {1'b1, 2'd0, 8'h02, 8'd100},
    {1'b1, 2'd1, 8'h01, 8'd150}, {1'b1, 2'd2, 8'h0E, 8'd250},
    {1'b1, 2'd2, 8'h7C, 8'd250}, {1'b1, 2'd3, 8'h01, 8'd10},
    {1'b1, 2'd2, 8'h00, 8'd50},  {1'b1, 2'd0, 8'hF0, 8'd10},
    {1'b1, 2'd2, 8'h24, 8'd250}, {1'b1, 2'd1, 8'h40, 8'd30},
    {1'b1, 2'd3, 8'h00, 8'd20}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd_check(2'd0, 8'h00, "R1 counter after reset");
    rd_check(2'd1, 8'hFF, "R1 period after reset");
    rd_check(2'd2, 8'h00, "R1 control after reset");
    rd_check(2'd3, 8'h00, "R1 flag after reset");
    check(match == 1'b0, "R1 match after reset", match, 0);

    // vector table walked by one loop
    for (int v = 0; v < NV; v++) begin
      cyc(VECS[v].wr, VECS[v].a, VECS[v].d);
      for (int j = 0; j < int'(VECS[v].hold); j++) cyc(1'b0, 2'(j), 8'd0);
    end

    // R2 register access
    cyc(1'b1, 2'd2, 8'h00);
    cyc(1'b1, 2'd0, 8'h5A);
    rd_check(2'd0, 8'h5A, "R2 counter readback");
    cyc(1'b1, 2'd1, 8'h33);
    rd_check(2'd1, 8'h33, "R2 period readback");
    cyc(1'b1, 2'd2, 8'h7B);
    rd_check(2'd2, 8'h7B, "R2 control readback");
    cyc(1'b1, 2'd2, 8'h83);
    rd_check(2'd2, 8'h03, "R2 control bit7 reads 0");

    // R3 base rate, prescale 1
    cyc(1'b1, 2'd1, 8'hFF);
    cyc(1'b1, 2'd2, 8'h04);
    cyc(1'b1, 2'd0, 8'h00);
    idle(39);
    rd_check(2'd0, 8'd10, "R3 ten advances in 40 clocks");
    // R4 prescale 4 and 16
    cyc(1'b1, 2'd2, 8'h05);
    cyc(1'b1, 2'd0, 8'h00);
    idle(159);
    rd_check(2'd0, 8'd10, "R4 prescale 4");
    cyc(1'b1, 2'd2, 8'h06);
    cyc(1'b1, 2'd0, 8'h00);
    idle(639);
    rd_check(2'd0, 8'd10, "R4 prescale 16");
    // R8 control write keeps counter, R3 stopped holds
    cyc(1'b1, 2'd2, 8'h02);
    rd_check(2'd0, 8'd10, "R8 control write keeps counter");
    idle(99);
    rd_check(2'd0, 8'd10, "R3 stopped counter holds");

    // R8 control write clears prescale count
    cyc(1'b1, 2'd2, 8'h06);
    cyc(1'b1, 2'd0, 8'h00);
    idle(31);
    cyc(1'b1, 2'd2, 8'h06);
    idle(31);
    rd_check(2'd0, 8'd0, "R8 prescale cleared by control write");
    idle(31);
    rd_check(2'd0, 8'd1, "R8 advance after 16 fresh ticks");

    // R6 postscale N=2 -> flag on third match
    cyc(1'b1, 2'd1, 8'h03);
    cyc(1'b1, 2'd2, 8'h14);
    cyc(1'b1, 2'd3, 8'h00);
    cyc(1'b1, 2'd0, 8'h00);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      cyc(1'b0, 2'd0, 8'd0);
      #1;
      if (irq) break;
      if (match) n++;
    end
    check(irq == 1'b1, "R6 flag raised", irq, 1);
    check(n == 3, "R6 matches before flag", n, 3);

    // R5 reload to zero after match
    for (int k = 0; k < 100; k++) begin
      cyc(1'b0, 2'd0, 8'd0);
      #1;
      if (match) break;
    end
    rd_check(2'd0, 8'h00, "R5 counter zero after match");

    // R7 write of 1 ignored, write of 0 clears
    cyc(1'b1, 2'd3, 8'h01);
    rd_check(2'd3, 8'h01, "R7 write 1 has no effect");
    cyc(1'b1, 2'd2, 8'h00);
    cyc(1'b1, 2'd3, 8'h00);
    rd_check(2'd3, 8'h00, "R7 write 0 clears flag");

    // R7 set wins over clear in same cycle
    cyc(1'b1, 2'd2, 8'h04);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      cmp_model();
      if (match) begin
        wr_en = 1'b1; addr = 2'd3; wdata = 8'h00;
        break;
      end
      wr_en = 1'b0;
    end
    cyc(1'b0, 2'd3, 8'd0);
    #1;
    check(irq == 1'b1, "R7 set wins over clear", irq, 1);

    // R9 counter above period wraps
    cyc(1'b1, 2'd2, 8'h00);
    cyc(1'b1, 2'd1, 8'h20);
    cyc(1'b1, 2'd0, 8'h30);
    cyc(1'b1, 2'd2, 8'h04);
    n = 0;
    for (int k = 1; k < 1200; k++) begin
      cyc(1'b0, 2'd0, 8'd0);
      #1;
      if (match) begin n = k; break; end
    end
    check(n >= 958 && n <= 966, "R9 match only after wrap", n, 962);
    rd_check(2'd0, 8'h00, "R9 counter zero after wrapped match");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule